// File: doc/BRIEF.md
# Byte-Pooled Watermark FIFO

This block is a first-in first-out buffer built on a fixed pool of 256 bytes. It sits on either the transmit or the receive side of a serial controller. One side pushes entries and the other side pops them. An entry is 8, 16 or 32 bits wide, chosen by a control field. Because the pool size is fixed in bytes, the number of entries the buffer holds depends on the width that is selected.

Configuration comes in through three write strobes:
- An operation word flushes the buffer and starts or stops it.
- A control word sets the entry width and an 8-bit threshold.
- A level-check word holds three compare levels, counted in 32-bit units.

The block drives a 10-bit status word and event lines for an interrupt block. The events are threshold reached, full and empty. Two further pulses report a push that was refused and a pop that was refused. The parameter `IS_RX` sets the direction of the threshold compare: a receive instance fires as the buffer fills, and a transmit instance fires as it drains.

Top module: `fifo_wm`

## Requirements
- R1: The control field `ctrl_data[1:0]` sets the entry width: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes. Capacity is therefore 256, 128 or 64 entries. Full is flagged exactly when that many entries are held.
- R2: A write of the operation word with bit 0 set empties the buffer and returns both pointers to the start. Bit 1 of the same write sets the run state. A write with bit 1 clear stops the buffer and keeps its contents. Those contents pop out intact after a later start.
- R3: The status word reports three things. Bits 7:0 hold the entry count modulo 256. Bit 8 is set when the buffer is full. Bit 9 is set when it is empty. After reset the status word reads 0x200.
- R4: Entries pop in the order they were pushed. An entry is stored in little-endian byte order. Bits of `pop_data` above the selected width read 0. `pop_data` shows the oldest entry while the buffer is not empty.
- R5: The threshold is `ctrl_data[9:2]`. The event `evt_thresh` compares the entry count against it. When `IS_RX`=1 it is high while count >= threshold. When `IS_RX`=0 it is high while count <= threshold.
- R6: `evt_full` follows status bit 8 and `evt_empty` follows status bit 9 in every cycle.
- R7: A push while full is ignored, and `err_push` is high for the one following cycle. A pop while empty is ignored, and `err_pop` is high for the one following cycle.
- R8: The level-check word holds three 6-bit fields: low in bits 5:0, middle in bits 15:10 and high in bits 25:20. Each of `lvl_lo`, `lvl_mid` and `lvl_hi` is high while the occupied byte count divided by 4 is at least its field.
- R9: A push and a pop accepted in the same cycle leave the count unchanged. Both entries keep their order and value.
- R10: While stopped, push and pop requests change nothing and raise no error pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_wr | input | 1 | Write strobe for the operation word |
| op_data | input | 2 | Bit 0 flushes the buffer, bit 1 sets the run state |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_data | input | 10 | Bits 1:0 entry width, bits 9:2 threshold |
| lvl_wr | input | 1 | Write strobe for the level-check word |
| lvl_data | input | 26 | Low level in bits 5:0, middle in 15:10, high in 25:20 |
| push_valid | input | 1 | Push request |
| push_data | input | 32 | Entry to push, aligned to bit 0 |
| pop_req | input | 1 | Pop request |
| pop_data | output | 32 | Oldest entry, upper bits zero |
| status | output | 10 | Empty, full and entry count |
| evt_thresh | output | 1 | Threshold reached |
| evt_full | output | 1 | Buffer full |
| evt_empty | output | 1 | Buffer empty |
| err_push | output | 1 | One-cycle pulse after a refused push |
| err_pop | output | 1 | One-cycle pulse after a refused pop |
| lvl_lo | output | 1 | Occupancy at or above the low level |
| lvl_mid | output | 1 | Occupancy at or above the middle level |
| lvl_hi | output | 1 | Occupancy at or above the high level |

## Verification
Every width code, including the alias code 3, is driven through a complete fill to capacity, one extra push, a complete drain and one extra pop. This separates capacity, full and empty timing, the lane masking of `pop_data`, and wrap of the count modulo 256 when byte entries fill the pool. A receive instance and a transmit instance run side by side on the same stimulus with the threshold at half capacity, so the two compare directions can be told apart at every level. Two further patterns are also run:
- A stop-and-restart sequence with a flush shows that contents are retained while stopped and discarded by a flush.
- A run of simultaneous push and pop cycles shows that the count holds while the data stays in order.

// File: rtl/fifo_wm_pkg.sv
package fifo_wm_pkg;

  typedef struct packed {
    logic [5:0] lo;
    logic [5:0] mid;
    logic [5:0] hi;
  } lvl_chk_t;

  // bytes occupied by one entry for a width code
  function automatic logic [2:0] lane_count(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // log2 of lane_count
  function automatic logic [1:0] lane_shift(input logic [1:0] sel);
    case (sel)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/fifo_wm_cfg.sv
module fifo_wm_cfg
  import fifo_wm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_wr,
  input  logic [1:0]  op_data,
  input  logic        ctrl_wr,
  input  logic [9:0]  ctrl_data,
  input  logic        lvl_wr,
  input  logic [25:0] lvl_data,
  output logic        run,
  output logic        flush,
  output logic [1:0]  wsel,
  output logic [7:0]  thr,
  output lvl_chk_t    chk
);

  assign flush = op_wr & op_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      wsel <= 2'd0;
      thr  <= 8'd0;
      chk  <= '0;
    end else begin
      if (op_wr) run <= op_data[1];
      if (ctrl_wr) begin
        wsel <= ctrl_data[1:0];
        thr  <= ctrl_data[9:2];
      end
      if (lvl_wr) begin
        chk.lo  <= lvl_data[5:0];
        chk.mid <= lvl_data[15:10];
        chk.hi  <= lvl_data[25:20];
      end
    end
  end

endmodule

// File: rtl/fifo_wm_store.sv
module fifo_wm_store #(
  parameter int BYTES = 256,
  parameter int LANES = 4,
  localparam int AW = $clog2(BYTES),
  localparam int CW = AW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               push_ok,
  input  logic               pop_ok,
  input  logic [2:0]         nbytes,
  input  logic [8*LANES-1:0] push_data,
  output logic [CW-1:0]      cnt,
  output logic [8*LANES-1:0] pop_data
);

  logic [7:0]    mem [BYTES];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] step;

  assign step = CW'(nbytes);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= wptr + AW'(nbytes);
      if (pop_ok)  rptr <= rptr + AW'(nbytes);
      cnt <= cnt + (push_ok ? step : '0) - (pop_ok ? step : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) begin
      for (int k = 0; k < LANES; k++) begin
        if (3'(k) < nbytes) mem[wptr + AW'(k)] <= push_data[8*k +: 8];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      pop_data[8*k +: 8] = (3'(k) < nbytes) ? mem[rptr + AW'(k)] : 8'h00;
    end
  end

endmodule

// File: rtl/fifo_wm_flags.sv
module fifo_wm_flags
  import fifo_wm_pkg::*;
#(
  parameter int BYTES = 256,
  parameter bit IS_RX = 1'b1,
  localparam int CW = $clog2(BYTES) + 1
) (
  input  logic [CW-1:0] cnt,
  input  logic [1:0]    wsel,
  input  logic [7:0]    thr,
  input  lvl_chk_t      chk,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] level,
  output logic          thresh_hit,
  output logic          at_lo,
  output logic          at_mid,
  output logic          at_hi
);

  logic [CW-1:0] nb;
  logic [CW-1:0] units;

  assign nb    = CW'(lane_count(wsel));
  assign full  = cnt > (CW'(BYTES) - nb);
  assign empty = cnt < nb;
  assign level = cnt >> lane_shift(wsel);
  assign units = cnt >> 2;

  generate
    if (IS_RX) begin : g_fill
      assign thresh_hit = level >= CW'(thr);
    end else begin : g_drain
      assign thresh_hit = level <= CW'(thr);
    end
  endgenerate

  assign at_lo  = units >= CW'(chk.lo);
  assign at_mid = units >= CW'(chk.mid);
  assign at_hi  = units >= CW'(chk.hi);

endmodule

// File: rtl/fifo_wm.sv
module fifo_wm
  import fifo_wm_pkg::*;
#(
  parameter int BYTES = 256,
  parameter bit IS_RX = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_wr,
  input  logic [1:0]  op_data,
  input  logic        ctrl_wr,
  input  logic [9:0]  ctrl_data,
  input  logic        lvl_wr,
  input  logic [25:0] lvl_data,
  input  logic        push_valid,
  input  logic [31:0] push_data,
  input  logic        pop_req,
  output logic [31:0] pop_data,
  output logic [9:0]  status,
  output logic        evt_thresh,
  output logic        evt_full,
  output logic        evt_empty,
  output logic        err_push,
  output logic        err_pop,
  output logic        lvl_lo,
  output logic        lvl_mid,
  output logic        lvl_hi
);

  localparam int LANES = 4;
  localparam int CW = $clog2(BYTES) + 1;

  logic          run, flush, full, empty, push_ok, pop_ok;
  logic [1:0]    wsel;
  logic [7:0]    thr;
  lvl_chk_t      chk;
  logic [CW-1:0] cnt, level;

  fifo_wm_cfg u_cfg (
    .clk(clk), .rst_n(rst_n),
    .op_wr(op_wr), .op_data(op_data),
    .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
    .lvl_wr(lvl_wr), .lvl_data(lvl_data),
    .run(run), .flush(flush), .wsel(wsel), .thr(thr), .chk(chk)
  );

  assign push_ok = run & push_valid & ~full;
  assign pop_ok  = run & pop_req & ~empty;

  fifo_wm_store #(.BYTES(BYTES), .LANES(LANES)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push_ok(push_ok), .pop_ok(pop_ok), .nbytes(lane_count(wsel)),
    .push_data(push_data), .cnt(cnt), .pop_data(pop_data)
  );

  fifo_wm_flags #(.BYTES(BYTES), .IS_RX(IS_RX)) u_flags (
    .cnt(cnt), .wsel(wsel), .thr(thr), .chk(chk),
    .full(full), .empty(empty), .level(level), .thresh_hit(evt_thresh),
    .at_lo(lvl_lo), .at_mid(lvl_mid), .at_hi(lvl_hi)
  );

  assign status    = {empty, full, 8'(level)};
  assign evt_full  = full;
  assign evt_empty = empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_push <= 1'b0;
      err_pop  <= 1'b0;
    end else begin
      err_push <= run & push_valid & full;
      err_pop  <= run & pop_req & empty;
    end
  end

endmodule

// File: rtl/fifo_wm_chk.sv
module fifo_wm_chk #(
  parameter int BYTES = 256,
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_wr,
  input logic          run,
  input logic          push_valid,
  input logic          pop_req,
  input logic          full,
  input logic          empty,
  input logic          err_push,
  input logic          err_pop,
  input logic [CW-1:0] cnt
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(BYTES)); // R1

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R3

  AST_PUSH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    run && push_valid && full && !op_wr |=> err_push); // R7

  AST_POP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    run && pop_req && empty && !op_wr |=> err_pop); // R7

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    run && push_valid && full && !pop_req && !op_wr |=> $stable(cnt)); // R7

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !op_wr |=> $stable(cnt) && !err_push && !err_pop); // R10

  AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    run && push_valid && pop_req && !full && !empty && !op_wr |=> $stable(cnt)); // R9

endmodule

bind fifo_wm fifo_wm_chk #(.BYTES(BYTES), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .run(run),
  .push_valid(push_valid), .pop_req(pop_req), .full(full), .empty(empty),
  .err_push(err_push), .err_pop(err_pop), .cnt(cnt)
);

// File: tb/test_fifo_wm.sv
`timescale 1ns/1ps
module test_fifo_wm;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_wr = 1'b0, ctrl_wr = 1'b0, lvl_wr = 1'b0;
  logic [1:0]  op_data = '0;
  logic [9:0]  ctrl_data = '0;
  logic [25:0] lvl_data = '0;
  logic        push_valid = 1'b0, pop_req = 1'b0;
  logic [31:0] push_data = '0;

  logic [31:0] rx_pop, tx_pop;
  logic [9:0]  rx_st, tx_st;
  logic rx_th, rx_fu, rx_em, rx_ep, rx_eq, rx_lo, rx_mi, rx_hi;
  logic tx_th, tx_fu, tx_em, tx_ep, tx_eq, tx_lo, tx_mi, tx_hi;

  always #2.5 clk = ~clk;

  fifo_wm #(.IS_RX(1'b1)) i_fifo_wm (
    .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .op_data(op_data),
    .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data), .lvl_wr(lvl_wr), .lvl_data(lvl_data),
    .push_valid(push_valid), .push_data(push_data), .pop_req(pop_req),
    .pop_data(rx_pop), .status(rx_st), .evt_thresh(rx_th), .evt_full(rx_fu),
    .evt_empty(rx_em), .err_push(rx_ep), .err_pop(rx_eq),
    .lvl_lo(rx_lo), .lvl_mid(rx_mi), .lvl_hi(rx_hi));

  fifo_wm #(.IS_RX(1'b0)) i_fifo_wm_tx (
    .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .op_data(op_data),
    .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data), .lvl_wr(lvl_wr), .lvl_data(lvl_data),
    .push_valid(push_valid), .push_data(push_data), .pop_req(pop_req),
    .pop_data(tx_pop), .status(tx_st), .evt_thresh(tx_th), .evt_full(tx_fu),
    .evt_empty(tx_em), .err_push(tx_ep), .err_pop(tx_eq),
    .lvl_lo(tx_lo), .lvl_mid(tx_mi), .lvl_hi(tx_hi));

  int checks = 0, errors = 0;
  int m_run = 0, m_cnt = 0, m_w = 0, m_thr = 0, m_lo = 0, m_mid = 0, m_hi = 0;
  int qh = 0, qt = 0;
  logic [31:0] qv [256];

  function automatic int nbf(int w);
    return (w == 0) ? 1 : ((w == 1) ? 2 : 4);
  endfunction

  function automatic logic [31:0] maskf(int w);
    return (w == 0) ? 32'h0000_00FF : ((w == 1) ? 32'h0000_FFFF : 32'hFFFF_FFFF);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outs(bit ep, bit eq);
    int lvl, units;
    bit full_m, empty_m;
    lvl     = m_cnt / nbf(m_w);
    units   = m_cnt / 4;
    full_m  = m_cnt > 256 - nbf(m_w);
    empty_m = m_cnt < nbf(m_w);
    check("R3 status rx", rx_st, {empty_m, full_m, 8'(lvl)});
    check("R3 status tx", tx_st, {empty_m, full_m, 8'(lvl)});
    check("R5 rx threshold", rx_th, lvl >= m_thr);
    check("R5 tx threshold", tx_th, lvl <= m_thr);
    check("R6 full event", rx_fu, full_m);
    check("R6 empty event", tx_em, empty_m);
    check("R7 push error", rx_ep, ep);
    check("R7 pop error", tx_eq, eq);
    check("R8 low level", rx_lo, units >= m_lo);
    check("R8 middle level", tx_mi, units >= m_mid);
    check("R8 high level", rx_hi, units >= m_hi);
  endtask

  task automatic cyc(bit p, logic [31:0] d, bit q, string req);
    bit full_m, empty_m, ep, eq;
    push_valid = p; push_data = d; pop_req = q;
    #1;
    full_m  = m_cnt > 256 - nbf(m_w);
    empty_m = m_cnt < nbf(m_w);
    if (q && m_run != 0 && !empty_m) begin
      check({req, " R4 pop data rx"}, rx_pop, qv[qh]);
      check({req, " R4 pop data tx"}, tx_pop, qv[qh]);
    end
    @(posedge clk);
    ep = (m_run != 0) && p && full_m;
    eq = (m_run != 0) && q && empty_m;
    if (m_run != 0 && p && !full_m) begin
      qv[qt] = d & maskf(m_w); qt = (qt + 1) % 256; m_cnt += nbf(m_w);
    end
    if (m_run != 0 && q && !empty_m) begin
      qh = (qh + 1) % 256; m_cnt -= nbf(m_w);
    end
    @(negedge clk);
    push_valid = 1'b0; pop_req = 1'b0;
    check_outs(ep, eq);
  endtask

  task automatic do_op(logic [1:0] v);
    op_wr = 1'b1; op_data = v;
    @(posedge clk);
    if (v[0]) begin m_cnt = 0; qh = 0; qt = 0; end
    m_run = v[1];
    @(negedge clk);
    op_wr = 1'b0;
    check_outs(1'b0, 1'b0);
  endtask

  task automatic do_ctrl(int w, int t);
    ctrl_wr = 1'b1; ctrl_data = {8'(t), 2'(w)};
    @(posedge clk);
    m_w = w; m_thr = t;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic do_lvl(int lo, int mid, int hi);
    lvl_wr = 1'b1;
    lvl_data = '0;
    lvl_data[5:0] = 6'(lo); lvl_data[15:10] = 6'(mid); lvl_data[25:20] = 6'(hi);
    @(posedge clk);
    m_lo = lo; m_mid = mid; m_hi = hi;
    @(negedge clk);
    lvl_wr = 1'b0;
  endtask

  function automatic logic [31:0] pat(int i, int w);
    return 32'hA5C3_9E71 ^ (32'(i) * 32'h0103_0507) ^ 32'(w);
  endfunction

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R3 reset status rx", rx_st, 10'h200);
    check("R3 reset status tx", tx_st, 10'h200);
    rst_n = 1'b1;
    @(negedge clk);
    check_outs(1'b0, 1'b0);
    do_lvl(2, 32, 62);

    // R1 R4 R7: fill, overflow, drain, underflow for every width code
    for (int w = 0; w < 4; w++) begin
      int cap;
      cap = 256 / nbf(w);
      do_ctrl(w, cap / 2);
      do_op(2'b11);
      for (int i = 0; i < cap; i++) cyc(1'b1, pat(i, w), 1'b0, "R1 fill");
      check("R1 full at capacity", rx_st[8], 1'b1);
      cyc(1'b1, 32'hDEAD_BEEF, 1'b0, "R7 overflow");
      for (int i = 0; i < cap; i++) cyc(1'b0, '0, 1'b1, "R4 drain");
      cyc(1'b0, '0, 1'b1, "R7 underflow");
    end

    // R2 R10: stop keeps contents, restart pops them, flush clears
    do_ctrl(2, 3);
    do_op(2'b11);
    for (int i = 0; i < 5; i++) cyc(1'b1, pat(i + 300, 2), 1'b0, "R2 load");
    do_op(2'b00);
    cyc(1'b1, 32'h1234_5678, 1'b0, "R10 push stopped");
    cyc(1'b0, '0, 1'b1, "R10 pop stopped");
    check("R10 level kept", rx_st[7:0], 8'd5);
    do_op(2'b10);
    for (int i = 0; i < 5; i++) cyc(1'b0, '0, 1'b1, "R2 restart pop");
    for (int i = 0; i < 3; i++) cyc(1'b1, pat(i, 1), 1'b0, "R2 reload");
    do_op(2'b01);
    check("R2 flush empties", rx_st, 10'h200);
    cyc(1'b1, 32'h0F0F_0F0F, 1'b0, "R10 push after flush-stop");

    // R9: simultaneous push and pop at halfword width
    do_ctrl(1, 4);
    do_op(2'b11);
    for (int i = 0; i < 4; i++) cyc(1'b1, pat(i + 500, 1), 1'b0, "R9 prime");
    for (int i = 0; i < 20; i++) cyc(1'b1, pat(i + 600, 1), 1'b1, "R9 same cycle");
    check("R9 level held", rx_st[7:0], 8'd4);
    for (int i = 0; i < 5; i++) cyc(1'b0, '0, 1'b1, "R9 drain");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule